// File: doc/BRIEF.md
# Watchdog Timer with Clock-Stabilization Wait

This block is a watchdog and interval timer that also times the wait for the oscillator to settle. The oscillator settles when the chip wakes from a standby state, or after the PLL frequency is changed. An 8-bit up-counter advances on a count clock chosen by a 3-bit select from a set of prescaled versions of the input clock. Software sets up the timer through a keyed write port. One register holds the counter value. A control/status register holds a run bit, a mode bit that picks a reset or an interrupt on overflow, a sticky overflow flag and the clock select.

The block drives a clock-enable output, `clk_run`, for the rest of the system. A standby request stops the system clock, and the counter then waits in that state. A rising edge on the non-maskable wake input, or a high level on the ordinary wake input, starts the stabilization count. A write strobe to the frequency-control register stops the clock and starts the stabilization count at once. When that count overflows, the clock is enabled again. If the run bit is clear, this happens silently: the flag does not change and the counter stays at zero. If the run bit is set, the overflow also raises the configured reset or interrupt pulse.

Top module: `wdg_stab_timer`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the outputs are as follows: `cnt_val` is 0x00, `csr_val` is 0x00, `clk_run` is 1, and `wdt_rst` and `itv_irq` are 0.
- R2: A write with `wr_addr`=0 loads `wr_data[7:0]` into the counter only when `wr_data[15:8]` is 0x5A. A write with `wr_addr`=1 updates the control register only when `wr_data[15:8]` is 0xA5. A write with any other key has no effect.
- R3: `csr_val[2:0]`=n picks a count clock of the input clock divided by 32·2^n. While the counter runs, it increases by one once per count-clock period.
- R4: `csr_val` fields are: bit 7 run, bit 6 mode (1 = reset, 0 = interval), bit 5 overflow flag, bits 4:3 spare, and bits 2:0 select. With run=1 and mode=0, the wrap from 0xFF to 0x00 gives a one-cycle `itv_irq` pulse and sets the flag, in the same cycle in which `cnt_val` shows 0x00. Counting then continues.
- R5: With run=1 and mode=1, the wrap gives a one-cycle `wdt_rst` pulse and sets the flag. `itv_irq` stays 0.
- R6: A `standby_req` pulse while the clock runs drops `clk_run` one cycle later. The counter then holds its value until a wake event arrives.
- R7: In standby, a rising edge of `wake_nmi` or a high level of `wake_irq` starts the stabilization count and clears the prescaler. The first increment comes one full count-clock period after the starting edge.
- R8: A `freq_wr` pulse while the clock runs drops `clk_run` one cycle later and starts the stabilization count with a cleared prescaler.
- R9: A stabilization overflow with run=0 sets `clk_run` to 1 in the cycle in which `cnt_val` shows 0x00. The flag is not set, no pulse is raised, and the counter then stays at 0x00.
- R10: A stabilization overflow with run=1 also restarts the clock, and it raises the configured pulse and sets the flag.
- R11: A keyed control write with bit 5 at 0 clears the flag. A keyed control write with bit 5 at 1 leaves the flag unchanged.
- R12: With run=0 and the clock running, the counter does not change except through a keyed counter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator/input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = counter, 1 = control/status |
| wr_data | input | 16 | Key in [15:8], value in [7:0] |
| standby_req | input | 1 | Enter standby, stopping the clock |
| wake_nmi | input | 1 | Non-maskable wake, edge-sensitive |
| wake_irq | input | 1 | Ordinary wake request, level-sensitive |
| freq_wr | input | 1 | Frequency-control register write strobe |
| cnt_val | output | 8 | Counter value |
| csr_val | output | 8 | Control/status register value |
| clk_run | output | 1 | Clock enable for the system |
| wdt_rst | output | 1 | Watchdog reset pulse |
| itv_irq | output | 1 | Interval-timer interrupt pulse |

## Verification
A wrong prescaler phase or a wrong select decode shows up as an error in the exact cycle count from a wake edge to the rise of `clk_run`. This is visible within one count-clock period, at most 4096 cycles. A sequencer stuck in standby or in stabilization shows up as `clk_run` never rising. A stabilization overflow wrongly treated as a watchdog overflow shows up in the same cycle: the flag in `csr_val` sets, or a pulse appears. A key decoder that lets a write through shows up on `cnt_val` or `csr_val` in the cycle after the write.

// File: rtl/wst_pkg.sv
// Shared types for the watchdog/stabilization timer.
// Assumes: 8-bit control register layout fixed by the field order below.
package wst_pkg;

    // Sequencer states: clock running, clock halted awaiting wake, stabilization count
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_STAB = 2'd2
    } wst_state_e;

    // Control/status register fields, MSB first
    typedef struct packed {
        logic       run;
        logic       wdog;
        logic       flag;
        logic [1:0] spare;
        logic [2:0] sel;
    } wst_csr_t;

endpackage

// File: rtl/wst_prescaler.sv
// Free-running prescaler producing one count tick per selected period.
// Period for select n is 2**(BASE_LOG2+n) input clocks. Assumes BASE_LOG2 >= 1.
// Clearing restarts the period so the first tick arrives a full period later.
module wst_prescaler #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int PRE_W = BASE_LOG2 + NSEL - 1;

    logic [PRE_W-1:0] pre_q;
    logic [NSEL-1:0]  tick_vec;

    // Prescale count register, cleared by reset or start of a stabilization count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre_q <= '0;
        else               pre_q <= pre_q + 1'b1;
    end

    // One terminal-count detector per select value
    for (genvar gi = 0; gi < NSEL; gi++) begin : g_tap
        assign tick_vec[gi] = &pre_q[BASE_LOG2+gi-1:0];
    end

    // Pick the detector named by the select field
    always_comb tick = tick_vec[sel];

    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick); // R7

endmodule

// File: rtl/wst_counter.sv
// Up-counter with parallel load; reports a wrap when incrementing from all ones.
// Assumes load takes priority over increment in the same cycle.
module wst_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    // Counter state: load, step or hold
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (load) cnt <= load_val;
        else if (inc)  cnt <= cnt + 1'b1;
    end

    // Wrap is an increment out of the all-ones value
    always_comb wrap = inc && !load && (&cnt);

    AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (cnt == $past(cnt) + 1'b1)); // R3
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(cnt)); // R12

endmodule

// File: rtl/wst_ctrl.sv
// Keyed write decode and control/status register.
// Assumes the key sits in the upper byte of the write data; the flag is
// sticky, set by overflow events and cleared only by a keyed write of 0.
module wst_ctrl #(
    parameter int          KEY_W   = 8,
    parameter int          VAL_W   = 8,
    parameter logic [KEY_W-1:0] KEY_CNT = 8'h5A,
    parameter logic [KEY_W-1:0] KEY_CSR = 8'hA5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_addr,
    input  logic [KEY_W+VAL_W-1:0] wr_data,
    input  logic                   set_flag,
    output wst_pkg::wst_csr_t      csr,
    output logic                   cnt_load,
    output logic [VAL_W-1:0]       cnt_load_val
);
    import wst_pkg::*;

    logic [KEY_W-1:0] key;
    logic [VAL_W-1:0] val;
    logic             csr_wr;
    wst_csr_t         wr_csr;

    // Split the write word into key and value
    always_comb begin
        key    = wr_data[KEY_W+VAL_W-1:VAL_W];
        val    = wr_data[VAL_W-1:0];
        wr_csr = wst_csr_t'(val);
    end

    // Key check per target register
    always_comb begin
        cnt_load     = wr_en && !wr_addr && (key == KEY_CNT);
        csr_wr       = wr_en &&  wr_addr && (key == KEY_CSR);
        cnt_load_val = val;
    end

    // Control register fields and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr <= '0;
        end else begin
            if (csr_wr) begin
                csr.run   <= wr_csr.run;
                csr.wdog  <= wr_csr.wdog;
                csr.spare <= wr_csr.spare;
                csr.sel   <= wr_csr.sel;
            end
            if (set_flag)    csr.flag <= 1'b1;
            else if (csr_wr) csr.flag <= csr.flag & wr_csr.flag;
        end
    end

    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_addr && wr_data[KEY_W+VAL_W-1:VAL_W] == KEY_CSR) && !set_flag)
        |=> $stable(csr)); // R2
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !wr_csr.flag && !set_flag) |=> !csr.flag); // R11
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flag |=> !$rose(csr.flag)); // R9

endmodule

// File: rtl/wst_seq.sv
// Clock-gating sequencer: running, halted in standby, or counting out the
// stabilization wait. Assumes the frequency strobe wins over a standby
// request arriving in the same cycle.
module wst_seq (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                standby_req,
    input  logic                wake_nmi,
    input  logic                wake_irq,
    input  logic                freq_wr,
    input  logic                wrap,
    input  logic                run,
    output wst_pkg::wst_state_e state,
    output logic                pre_clr,
    output logic                count_en,
    output logic                ev_fire
);
    import wst_pkg::*;

    logic       nmi_q;
    logic       nmi_rise;
    wst_state_e state_d;

    // Previous level of the non-maskable wake input for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= wake_nmi;
    end

    // Next-state and prescaler-clear decode
    always_comb begin
        nmi_rise = wake_nmi && !nmi_q;
        state_d  = state;
        pre_clr  = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (freq_wr) begin
                    state_d = ST_STAB;
                    pre_clr = 1'b1;
                end else if (standby_req) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (nmi_rise || wake_irq) begin
                    state_d = ST_STAB;
                    pre_clr = 1'b1;
                end
            end
            ST_STAB: begin
                if (wrap) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_d;
    end

    // Counting is always on while stabilizing, and follows run otherwise
    always_comb begin
        count_en = (state == ST_STAB) || (state == ST_RUN && run);
        ev_fire  = wrap && run;
    end

    AST_HALT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !wake_irq && !(wake_nmi && !nmi_q)) |=> (state == ST_HALT)); // R7

endmodule

// File: rtl/wdg_stab_timer.sv
// Top: watchdog / interval timer whose overflow also ends the oscillator
// stabilization wait after standby or a frequency change.
// Assumes all inputs are synchronous to clk and rst_n is held until the
// oscillator is stable.
module wdg_stab_timer #(
    parameter int          CNT_W     = 8,
    parameter int          SEL_W     = 3,
    parameter int          BASE_LOG2 = 5,
    parameter int          KEY_W     = 8,
    parameter logic [KEY_W-1:0] KEY_CNT = 8'h5A,
    parameter logic [KEY_W-1:0] KEY_CSR = 8'hA5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_addr,
    input  logic [KEY_W+CNT_W-1:0] wr_data,
    input  logic                   standby_req,
    input  logic                   wake_nmi,
    input  logic                   wake_irq,
    input  logic                   freq_wr,
    output logic [CNT_W-1:0]       cnt_val,
    output logic [7:0]             csr_val,
    output logic                   clk_run,
    output logic                   wdt_rst,
    output logic                   itv_irq
);
    import wst_pkg::*;

    wst_csr_t         csr;
    wst_state_e       state;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             tick;
    logic             pre_clr;
    logic             count_en;
    logic             wrap;
    logic             ev_fire;

    wst_ctrl #(
        .KEY_W  (KEY_W),
        .VAL_W  (CNT_W),
        .KEY_CNT(KEY_CNT),
        .KEY_CSR(KEY_CSR)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .set_flag    (ev_fire),
        .csr         (csr),
        .cnt_load    (cnt_load),
        .cnt_load_val(cnt_load_val)
    );

    wst_prescaler #(
        .SEL_W    (SEL_W),
        .BASE_LOG2(BASE_LOG2)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (pre_clr),
        .sel  (csr.sel),
        .tick (tick)
    );

    wst_counter #(
        .W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_load_val),
        .inc     (tick && count_en),
        .cnt     (cnt_val),
        .wrap    (wrap)
    );

    wst_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_req(standby_req),
        .wake_nmi   (wake_nmi),
        .wake_irq   (wake_irq),
        .freq_wr    (freq_wr),
        .wrap       (wrap),
        .run        (csr.run),
        .state      (state),
        .pre_clr    (pre_clr),
        .count_en   (count_en),
        .ev_fire    (ev_fire)
    );

    // Register view and clock enable
    always_comb begin
        csr_val = csr;
        clk_run = (state == ST_RUN);
    end

    // One-cycle overflow pulses, steered by the mode bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_rst <= 1'b0;
            itv_irq <= 1'b0;
        end else begin
            wdt_rst <= ev_fire &&  csr.wdog;
            itv_irq <= ev_fire && !csr.wdog;
        end
    end

    AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wdt_rst, itv_irq})); // R4
    AST_WDOG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> csr_val[5]); // R5
    AST_STANDBY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run && standby_req) |=> !clk_run); // R6
    AST_FREQ_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_run && freq_wr) |=> !clk_run); // R8
    AST_RESUME_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_run) && !$past(cnt_load)) |-> (cnt_val == '0)); // R9
    AST_RESUME_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_run) && $past(csr.run)) |-> (wdt_rst || itv_irq)); // R10

endmodule

// File: tb/wdg_stab_timer_bench.sv
`timescale 1ns/1ps
// Bench: write vectors from a table, then directed timing and mode tests.
module wdg_stab_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        standby_req = 1'b0;
    logic        wake_nmi = 1'b0;
    logic        wake_irq = 1'b0;
    logic        freq_wr = 1'b0;
    logic [7:0]  cnt_val;
    logic [7:0]  csr_val;
    logic        clk_run;
    logic        wdt_rst;
    logic        itv_irq;

    int n_chk = 0;
    int n_bad = 0;
    int n_rst_pulse = 0;
    int n_irq_pulse = 0;

    always #2.5 clk = ~clk;

    wdg_stab_timer u_wdg_stab_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .standby_req(standby_req), .wake_nmi(wake_nmi),
        .wake_irq(wake_irq), .freq_wr(freq_wr), .cnt_val(cnt_val),
        .csr_val(csr_val), .clk_run(clk_run), .wdt_rst(wdt_rst), .itv_irq(itv_irq)
    );

    // Pulse counters sampled away from the active edge
    always @(negedge clk) begin
        if (wdt_rst) n_rst_pulse++;
        if (itv_irq) n_irq_pulse++;
    end

    // {addr, data, expected counter, expected control}
    localparam logic [32:0] VEC [8] = '{
        {1'b0, 16'h5A37, 8'h37, 8'h00},
        {1'b0, 16'h1288, 8'h37, 8'h00},
        {1'b1, 16'h5A83, 8'h37, 8'h00},
        {1'b1, 16'hA502, 8'h37, 8'h02},
        {1'b0, 16'hA5FF, 8'h37, 8'h02},
        {1'b0, 16'h5AC0, 8'hC0, 8'h02},
        {1'b1, 16'h0007, 8'hC0, 8'h02},
        {1'b1, 16'hA505, 8'hC0, 8'h05}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Cycles between two successive counter increments
    task automatic period(output int cyc);
        logic [7:0] v;
        v = cnt_val;
        for (int i = 0; i < 5000 && cnt_val == v; i++) @(negedge clk);
        v = cnt_val;
        cyc = 0;
        for (int i = 0; i < 5000 && cnt_val == v; i++) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic wait_cnt(input logic [7:0] v);
        for (int i = 0; i < 20000 && cnt_val != v; i++) @(negedge clk);
    endtask

    task automatic enter_standby();
        @(negedge clk); standby_req = 1'b1;
        @(negedge clk); standby_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int cyc;
        int p_rst;
        int p_irq;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cnt", cnt_val, 0);
        check("R1 csr", csr_val, 0);
        check("R1 clk_run", clk_run, 1);
        check("R1 pulses", {wdt_rst, itv_irq}, 0);
        rst_n = 1'b1;

        // R2: keyed writes from the table
        foreach (VEC[i]) begin
            wr(VEC[i][32], VEC[i][31:16]);
            check("R2 cnt", cnt_val, VEC[i][15:8]);
            check("R2 csr", csr_val, VEC[i][7:0]);
        end

        // R12: run=0, counter holds
        wr(1'b1, 16'hA500);
        repeat (300) @(negedge clk);
        check("R12 hold", cnt_val, 8'hC0);

        // R3: select 0 and 1 periods
        wr(1'b1, 16'hA580);
        period(cyc);
        check("R3 sel0 period", cyc, 32);
        wr(1'b1, 16'hA581);
        period(cyc);
        check("R3 sel1 period", cyc, 64);
        wr(1'b1, 16'hA584);
        period(cyc);
        check("R3 sel4 period", cyc, 512);

        // R4: interval overflow
        wr(1'b1, 16'hA500);
        wr(1'b0, 16'h5AFE);
        wr(1'b1, 16'hA580);
        wait_cnt(8'h00);
        check("R4 irq pulse", itv_irq, 1);
        check("R4 rst quiet", wdt_rst, 0);
        check("R4 flag", csr_val[5], 1);
        @(negedge clk);
        check("R4 pulse width", itv_irq, 0);
        wait_cnt(8'h01);
        check("R4 keeps counting", cnt_val, 8'h01);

        // R11: writing 1 keeps flag, writing 0 clears it
        wr(1'b1, 16'hA520);
        check("R11 keep", csr_val, 8'h20);
        wr(1'b1, 16'hA500);
        check("R11 clear", csr_val, 8'h00);

        // R5: watchdog overflow
        wr(1'b0, 16'h5AFF);
        wr(1'b1, 16'hA5C0);
        wait_cnt(8'h00);
        check("R5 rst pulse", wdt_rst, 1);
        check("R5 irq quiet", itv_irq, 0);
        check("R5 flag", csr_val[5], 1);
        wr(1'b1, 16'hA500);

        // R6/R7/R9: standby, NMI edge wake, silent resume
        wr(1'b0, 16'h5AF0);
        p_rst = n_rst_pulse; p_irq = n_irq_pulse;
        enter_standby();
        check("R6 clk stops", clk_run, 0);
        repeat (300) @(negedge clk);
        check("R6 held in standby", cnt_val, 8'hF0);
        @(negedge clk); wake_nmi = 1'b1;
        for (int k = 1; k <= 512; k++) @(negedge clk);
        check("R7 nmi before overflow", clk_run, 0);
        @(negedge clk);
        check("R7 nmi resume cycle", clk_run, 1);
        check("R9 park value", cnt_val, 8'h00);
        check("R9 flag clear", csr_val[5], 0);
        wake_nmi = 1'b0;
        repeat (200) @(negedge clk);
        check("R9 parked", cnt_val, 8'h00);
        check("R9 no pulses", (n_rst_pulse - p_rst) + (n_irq_pulse - p_irq), 0);

        // R8: frequency change strobe, select 1
        wr(1'b1, 16'hA501);
        wr(1'b0, 16'h5AFC);
        @(negedge clk); freq_wr = 1'b1;
        @(negedge clk); freq_wr = 1'b0;
        check("R8 clk stops", clk_run, 0);
        for (int k = 2; k <= 256; k++) @(negedge clk);
        check("R8 before overflow", clk_run, 0);
        @(negedge clk);
        check("R8 resume cycle", clk_run, 1);
        check("R8 flag clear", csr_val[5], 0);

        // R7: level wake path, select 0
        wr(1'b1, 16'hA500);
        wr(1'b0, 16'h5AF8);
        enter_standby();
        @(negedge clk); wake_irq = 1'b1;
        for (int k = 1; k <= 256; k++) @(negedge clk);
        check("R7 irq before overflow", clk_run, 0);
        @(negedge clk);
        check("R7 irq resume cycle", clk_run, 1);
        wake_irq = 1'b0;

        // R10: stabilization overflow with run set
        wr(1'b0, 16'h5AE0);
        wr(1'b1, 16'hA580);
        enter_standby();
        @(negedge clk); wake_nmi = 1'b1;
        for (int i = 0; i < 5000 && !clk_run; i++) @(negedge clk);
        check("R10 irq pulse", itv_irq, 1);
        check("R10 flag", csr_val[5], 1);
        check("R10 clk resumes", clk_run, 1);
        wake_nmi = 1'b0;

        summary();
    end
endmodule